// File: doc/BRIEF.md
# Programmable Memory Window Decoder

This block holds the configuration of four memory windows and compares every bus address against them. Software sets up each window through a byte-wide register port: an 8-bit index, write data, a write strobe, and combinational read data. The decoder raises one hit flag per window and a combined hit flag. Both flags are registered, so they appear one clock after the address is presented.

Each window has a base address and a second field. A read-only mode bit, fixed per window by a parameter, sets what the second field means. In mask mode it is a range-length mask: an address bit is compared with the base only where the mask bit is 1. In limit mode it is an exclusive upper bound, so a hit means base ≤ address < bound.

A parameter chooses between two register layouts, and only one is present in an instance. The narrow layout handles 24-bit addresses and stores address bits [23:8]; address bits [7:0] count as zero when compared. The wide layout handles 32-bit addresses and compares all 32 bits.

Top module: `mem_window_decoder`

## Requirements
- R1: While reset is low, every stored field resets to zero and all hit outputs are 0. After reset, every index reads 0x00, except the control registers, which read only their mode bit.
- R2: Narrow layout (LAYOUT32=0). Window w sits at index 0x40+8·w. Its offsets are: +0 base[23:16], +1 base[15:8], +2 control, +3 second field[23:16], +4 second field[15:8]. Every written byte reads back unchanged.
- R3: Wide layout (LAYOUT32=1). Window 0 starts at 0x76, and windows 1, 2 and 3 start at 0x80, 0x90 and 0xA0. Its offsets are: +0..+3 base[31:24], [23:16], [15:8], [7:0]; +4 control; +5..+8 second field from [31:24] down to [7:0]. Every written byte reads back unchanged.
- R4: Control bit 0 always reads the window's LIMIT_MODE parameter bit, where 1 means limit mode and 0 means mask mode. Writes never change it.
- R5: Width field. In the narrow layout, control bit 1 is read/write (1 = 16-bit, 0 = 8-bit) and bits [7:2] read 0. In the wide layout, bits [2:1] are read/write (00 = 8-bit, 01 = 16-bit, 11 = 32-bit) and bits [7:3] read 0.
- R6: Indices outside the layout, including the gaps between windows, read 0x00. Writes to them change no register.
- R7: A mask-mode window hits when the mask is nonzero and ((address XOR base) AND mask) is zero.
- R8: A limit-mode window hits when base < bound and base ≤ address < bound. The bound itself is excluded.
- R9: A mask-mode window with an all-zero mask never hits. A limit-mode window whose bound is not greater than its base never hits.
- R10: In the narrow layout, address bits [7:0] have no effect on any hit.
- R11: winHit[w] and anyHit update at the clock edge after the address is applied. anyHit equals the OR of winHit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regIdx | input | 8 | Register index |
| regWrData | input | 8 | Write data |
| regWrEn | input | 1 | Write strobe, one byte per cycle |
| regRdData | output | 8 | Read data for regIdx (combinational) |
| busAddr | input | 24 or 32 (LAYOUT32) | Address to decode |
| winHit | output | NUM_WIN | Registered per-window hit |
| anyHit | output | 1 | Registered combined hit |

## Verification
The bench aims at the edges of the limit compare: the address equal to the base, one below the bound, and equal to the bound. A decoder with an inclusive bound, or with the wrong direction in a magnitude compare, would then flag an extra address or miss the first one. It also uses windows that cannot hit: a zero mask, a bound equal to the base, and a bound below the base. A decoder that skipped the degenerate guard would hit everywhere or wrap around. Writing a distinct value to all 256 indices and then reading them all back exposes aliased or shifted offsets, reserved gaps that hold data, and a mode bit that software can overwrite. Narrow-layout sweeps change the low address byte, which must never matter.

// File: rtl/mwd_pkg.sv
package mwd_pkg;
  localparam int MAX_WIN   = 4;
  localparam int WIN_IDX_W = 2;

  typedef enum logic [1:0] {
    FLD_NONE = 2'd0,
    FLD_BASE = 2'd1,
    FLD_CTRL = 2'd2,
    FLD_HIGH = 2'd3
  } fieldT;

  // Decoded register access handed from the index decoder to the datapath.
  // byteSel counts from the most significant stored byte.
  typedef struct packed {
    fieldT                field;
    logic [WIN_IDX_W-1:0] win;
    logic [1:0]           byteSel;
    logic                 wrEn;
  } regStrobeT;
endpackage

// File: rtl/mwd_ctrl.sv
module mwd_ctrl
  import mwd_pkg::*;
#(
  parameter bit LAYOUT32 = 1'b0,
  parameter int NUM_WIN  = 4
) (
  input  logic [7:0] regIdx,
  input  logic       regWrEn,
  output regStrobeT  strb
);
  fieldT                decFld;
  logic [WIN_IDX_W-1:0] decWin;
  logic [1:0]           decSel;

  generate
    if (LAYOUT32) begin : g_wide
      logic [3:0] offs;
      logic       inRange;
      always_comb begin
        inRange = 1'b0;
        offs    = '0;
        decWin  = '0;
        if (regIdx >= 8'h76 && regIdx <= 8'h7E) begin
          inRange = 1'b1;
          offs    = 4'(regIdx - 8'h76);
        end else if (regIdx >= 8'h80 && regIdx <= 8'hAF) begin
          inRange = 1'b1;
          offs    = regIdx[3:0];
          decWin  = regIdx[5:4] + 2'd1;
        end
        decFld = FLD_NONE;
        decSel = '0;
        if (inRange) begin
          if (offs <= 4'd3) begin
            decFld = FLD_BASE;
            decSel = offs[1:0];
          end else if (offs == 4'd4) begin
            decFld = FLD_CTRL;
          end else if (offs <= 4'd8) begin
            decFld = FLD_HIGH;
            decSel = 2'(offs - 4'd5);
          end
        end
      end
    end else begin : g_narrow
      logic [2:0] offs;
      logic       inRange;
      always_comb begin
        inRange = (regIdx[7:5] == 3'b010);
        offs    = regIdx[2:0];
        decWin  = regIdx[4:3];
        decFld  = FLD_NONE;
        decSel  = '0;
        if (inRange) begin
          if (offs <= 3'd1) begin
            decFld = FLD_BASE;
            decSel = {1'b0, offs[0]};
          end else if (offs == 3'd2) begin
            decFld = FLD_CTRL;
          end else if (offs <= 3'd4) begin
            decFld = FLD_HIGH;
            decSel = 2'(offs - 3'd3);
          end
        end
      end
    end
  endgenerate

  always_comb begin
    strb.win     = decWin;
    strb.byteSel = decSel;
    strb.field   = (int'(decWin) >= NUM_WIN) ? FLD_NONE : decFld;
    strb.wrEn    = regWrEn && (strb.field != FLD_NONE);
  end
endmodule

// File: rtl/mwd_cmp.sv
module mwd_cmp #(
  parameter int AW    = 24,
  parameter bit LIMIT = 1'b0
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] high,
  output logic          hit
);
  generate
    if (LIMIT) begin : g_limit
      assign hit = (base < high) && (addr >= base) && (addr < high);
    end else begin : g_mask
      assign hit = (|high) && (((addr ^ base) & high) == '0);
    end
  endgenerate
endmodule

// File: rtl/mwd_datapath.sv
module mwd_datapath
  import mwd_pkg::*;
#(
  parameter bit                 LAYOUT32   = 1'b0,
  parameter int                 NUM_WIN    = 4,
  parameter logic [NUM_WIN-1:0] LIMIT_MODE = '0,
  localparam int AW = LAYOUT32 ? 32 : 24,
  localparam int NB = LAYOUT32 ? 4 : 2,
  localparam int SW = NB * 8,
  localparam int SHIFT = AW - SW
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobeT          strb,
  input  logic [7:0]         regWrData,
  input  logic [AW-1:0]      busAddr,
  output logic [7:0]         regRdData,
  output logic [NUM_WIN-1:0] hitVec,
  output logic [NUM_WIN-1:0] winHit,
  output logic               anyHit
);
  localparam logic [AW-1:0] ADDR_KEEP = {AW{1'b1}} << SHIFT;

  logic [AW-1:0]        addrCmp;
  logic [NUM_WIN*8-1:0] rdAll;

  assign addrCmp = busAddr & ADDR_KEEP;

  generate
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      logic [SW-1:0] baseQ;
      logic [SW-1:0] highQ;
      logic [1:0]    widthQ;
      logic [7:0]    rdByte;
      logic [AW-1:0] baseFull;
      logic [AW-1:0] highFull;
      logic          selW;

      assign selW = strb.wrEn && (int'(strb.win) == w);

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          baseQ  <= '0;
          highQ  <= '0;
          widthQ <= '0;
        end else if (selW) begin
          case (strb.field)
            FLD_BASE: begin
              for (int b = 0; b < NB; b++)
                if (strb.byteSel == 2'(b)) baseQ[(NB-1-b)*8 +: 8] <= regWrData;
            end
            FLD_HIGH: begin
              for (int b = 0; b < NB; b++)
                if (strb.byteSel == 2'(b)) highQ[(NB-1-b)*8 +: 8] <= regWrData;
            end
            FLD_CTRL: widthQ <= LAYOUT32 ? regWrData[2:1] : {1'b0, regWrData[1]};
            default: ;
          endcase
        end
      end

      always_comb begin
        rdByte = 8'h00;
        case (strb.field)
          FLD_BASE: begin
            for (int b = 0; b < NB; b++)
              if (strb.byteSel == 2'(b)) rdByte = baseQ[(NB-1-b)*8 +: 8];
          end
          FLD_HIGH: begin
            for (int b = 0; b < NB; b++)
              if (strb.byteSel == 2'(b)) rdByte = highQ[(NB-1-b)*8 +: 8];
          end
          FLD_CTRL: rdByte = {5'b0, widthQ, LIMIT_MODE[w]};
          default:  rdByte = 8'h00;
        endcase
      end

      assign rdAll[w*8 +: 8] = rdByte;
      assign baseFull = AW'(baseQ) << SHIFT;
      assign highFull = AW'(highQ) << SHIFT;

      mwd_cmp #(
        .AW   (AW),
        .LIMIT(LIMIT_MODE[w])
      ) u_cmp (
        .addr(addrCmp),
        .base(baseFull),
        .high(highFull),
        .hit (hitVec[w])
      );
    end
  endgenerate

  always_comb begin
    regRdData = 8'h00;
    for (int w = 0; w < NUM_WIN; w++)
      if (int'(strb.win) == w) regRdData = rdAll[w*8 +: 8];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winHit <= '0;
      anyHit <= 1'b0;
    end else begin
      winHit <= hitVec;
      anyHit <= |hitVec;
    end
  end
endmodule

// File: rtl/mem_window_decoder.sv
module mem_window_decoder
  import mwd_pkg::*;
#(
  parameter bit                 LAYOUT32   = 1'b0,
  parameter int                 NUM_WIN    = 4,
  parameter logic [NUM_WIN-1:0] LIMIT_MODE = 4'b1010,
  localparam int ADDR_W = LAYOUT32 ? 32 : 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [7:0]         regIdx,
  input  logic [7:0]         regWrData,
  input  logic               regWrEn,
  output logic [7:0]         regRdData,
  input  logic [ADDR_W-1:0]  busAddr,
  output logic [NUM_WIN-1:0] winHit,
  output logic               anyHit
);
  regStrobeT          strb;
  logic [NUM_WIN-1:0] hitVec;

  mwd_ctrl #(
    .LAYOUT32(LAYOUT32),
    .NUM_WIN (NUM_WIN)
  ) u_ctrl (
    .regIdx (regIdx),
    .regWrEn(regWrEn),
    .strb   (strb)
  );

  mwd_datapath #(
    .LAYOUT32  (LAYOUT32),
    .NUM_WIN   (NUM_WIN),
    .LIMIT_MODE(LIMIT_MODE)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .regWrData(regWrData),
    .busAddr  (busAddr),
    .regRdData(regRdData),
    .hitVec   (hitVec),
    .winHit   (winHit),
    .anyHit   (anyHit)
  );
endmodule

// File: rtl/mem_window_decoder_chk.sv
module mem_window_decoder_chk
  import mwd_pkg::*;
#(
  parameter bit                 LAYOUT32   = 1'b0,
  parameter int                 NUM_WIN    = 4,
  parameter logic [NUM_WIN-1:0] LIMIT_MODE = 4'b1010
) (
  input logic                 clk,
  input logic                 rstN,
  input fieldT                fieldSel,
  input logic [WIN_IDX_W-1:0] winSel,
  input logic [7:0]           regRdData,
  input logic [NUM_WIN-1:0]   hitVec,
  input logic [NUM_WIN-1:0]   winHit,
  input logic                 anyHit
);
  localparam logic [MAX_WIN-1:0] MODE_ALL = MAX_WIN'(LIMIT_MODE);

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (winHit == '0 && !anyHit));

  a_r4_mode_fixed: assert property (@(posedge clk) disable iff (!rstN)
    (fieldSel == FLD_CTRL) |-> (regRdData[0] == MODE_ALL[winSel]));

  a_r5_ctrl_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (fieldSel == FLD_CTRL) |->
      (LAYOUT32 ? (regRdData[7:3] == 5'd0) : (regRdData[7:2] == 6'd0)));

  a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (fieldSel == FLD_NONE) |-> (regRdData == 8'h00));

  a_r11_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (winHit == $past(hitVec)));

  a_r11_any_or: assert property (@(posedge clk) disable iff (!rstN)
    anyHit == (|winHit));
endmodule

bind mem_window_decoder mem_window_decoder_chk #(
  .LAYOUT32  (LAYOUT32),
  .NUM_WIN   (NUM_WIN),
  .LIMIT_MODE(LIMIT_MODE)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .fieldSel (strb.field),
  .winSel   (strb.win),
  .regRdData(regRdData),
  .hitVec   (hitVec),
  .winHit   (winHit),
  .anyHit   (anyHit)
);

// File: tb/mem_window_decoder_bench.sv
`timescale 1ns/1ps
module mem_window_decoder_bench;
  localparam logic [3:0] MODE = 4'b1010;

  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  regIdx, regWrData, rd24, rd32;
  logic        wrEn24, wrEn32;
  logic [23:0] a24;
  logic [31:0] a32;
  logic [3:0]  hit24, hit32;
  logic        any24, any32;

  int nCmp = 0;
  int nBad = 0;

  logic [15:0] b24[4], h24[4];
  logic        w24[4];
  logic [31:0] b32[4], h32[4];
  logic [1:0]  w32[4];

  always #2 clk = ~clk;

  mem_window_decoder #(.LAYOUT32(1'b0), .NUM_WIN(4), .LIMIT_MODE(MODE)) u_mem_window_decoder (
    .clk(clk), .rstN(rstN), .regIdx(regIdx), .regWrData(regWrData), .regWrEn(wrEn24),
    .regRdData(rd24), .busAddr(a24), .winHit(hit24), .anyHit(any24));

  mem_window_decoder #(.LAYOUT32(1'b1), .NUM_WIN(4), .LIMIT_MODE(MODE)) u_mem_window_decoder_w32 (
    .clk(clk), .rstN(rstN), .regIdx(regIdx), .regWrData(regWrData), .regWrEn(wrEn32),
    .regRdData(rd32), .busAddr(a32), .winHit(hit32), .anyHit(any32));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // field codes: 0 none, 1 base, 2 control, 3 second field
  function automatic void dec24(input int idx, output int fld, output int w, output int sel);
    int o;
    fld = 0; w = 0; sel = 0;
    if (idx >= 'h40 && idx < 'h60) begin
      w = (idx - 'h40) / 8;
      o = (idx - 'h40) % 8;
      if (o <= 1) begin fld = 1; sel = o; end
      else if (o == 2) fld = 2;
      else if (o <= 4) begin fld = 3; sel = o - 3; end
    end
  endfunction

  function automatic void dec32(input int idx, output int fld, output int w, output int sel);
    int o;
    fld = 0; w = 0; sel = 0; o = -1;
    if (idx >= 'h76 && idx <= 'h7E) o = idx - 'h76;
    else if (idx >= 'h80 && idx < 'hB0) begin w = (idx - 'h70) / 16; o = (idx - 'h70) % 16; end
    if (o >= 0 && o <= 3) begin fld = 1; sel = o; end
    else if (o == 4) fld = 2;
    else if (o >= 5 && o <= 8) begin fld = 3; sel = o - 5; end
  endfunction

  function automatic logic [7:0] exp24(input int idx);
    int f, w, s;
    dec24(idx, f, w, s);
    case (f)
      1: return b24[w][(1-s)*8 +: 8];
      2: return {6'b0, w24[w], MODE[w]};
      3: return h24[w][(1-s)*8 +: 8];
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp32(input int idx);
    int f, w, s;
    dec32(idx, f, w, s);
    case (f)
      1: return b32[w][(3-s)*8 +: 8];
      2: return {5'b0, w32[w], MODE[w]};
      3: return h32[w][(3-s)*8 +: 8];
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic hitExp(input logic lim, input logic [31:0] base, input logic [31:0] high,
                                  input logic [31:0] addr);
    if (lim) return (base < high) && (base <= addr) && (addr < high);
    return (high != 0) && (((addr ^ base) & high) == 0);
  endfunction

  task automatic wr(input int idx, input logic [7:0] d);
    int f, w, s;
    regIdx = 8'(idx); regWrData = d; wrEn24 = 1'b1; wrEn32 = 1'b1;
    @(posedge clk); #1;
    wrEn24 = 1'b0; wrEn32 = 1'b0;
    dec24(idx, f, w, s);
    if (f == 1) b24[w][(1-s)*8 +: 8] = d;
    if (f == 2) w24[w] = d[1];
    if (f == 3) h24[w][(1-s)*8 +: 8] = d;
    dec32(idx, f, w, s);
    if (f == 1) b32[w][(3-s)*8 +: 8] = d;
    if (f == 2) w32[w] = d[2:1];
    if (f == 3) h32[w][(3-s)*8 +: 8] = d;
  endtask

  task automatic sweepRead(input string req);
    for (int i = 0; i < 256; i++) begin
      regIdx = 8'(i);
      #1;
      chk(req, 32'(rd24), 32'(exp24(i)));
      chk(req, 32'(rd32), 32'(exp32(i)));
    end
  endtask

  task automatic setWin(input int w, input logic [15:0] bn, input logic [15:0] hn,
                        input logic [31:0] bw, input logic [31:0] hw);
    int s32;
    wr('h40 + 8*w, bn[15:8]); wr('h41 + 8*w, bn[7:0]);
    wr('h43 + 8*w, hn[15:8]); wr('h44 + 8*w, hn[7:0]);
    s32 = (w == 0) ? 'h76 : ('h70 + 16*w);
    for (int k = 0; k < 4; k++) begin
      wr(s32 + k, bw[(3-k)*8 +: 8]);
      wr(s32 + 5 + k, hw[(3-k)*8 +: 8]);
    end
  endtask

  task automatic chkHits(input logic [31:0] a, input string req);
    logic [3:0] e24, e32;
    a32 = a; a24 = a[23:0];
    @(posedge clk); #1;
    for (int w = 0; w < 4; w++) begin
      e24[w] = hitExp(MODE[w], {8'h0, b24[w], 8'h0}, {8'h0, h24[w], 8'h0}, {8'h0, a[23:8], 8'h0});
      e32[w] = hitExp(MODE[w], b32[w], h32[w], a);
    end
    chk({req, " narrow"}, 32'({any24, hit24}), 32'({|e24, e24}));
    chk({req, " wide"},   32'({any32, hit32}), 32'({|e32, e32}));
  endtask

  task automatic sweepNarrow(input string req);
    logic [7:0] mids[5];
    mids = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF};
    for (int hi = 0; hi < 'h40; hi++)
      for (int m = 0; m < 5; m++)
        for (int lo = 0; lo < 2; lo++)
          chkHits({8'h00, 8'(hi), mids[m], (lo == 1) ? 8'hFF : 8'h00}, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL R11 watchdog actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    logic [31:0] anchors[8];
    rstN = 1'b0; regIdx = '0; regWrData = '0; wrEn24 = 1'b0; wrEn32 = 1'b0; a24 = '0; a32 = '0;
    for (int w = 0; w < 4; w++) begin
      b24[w] = '0; h24[w] = '0; w24[w] = 1'b0; b32[w] = '0; h32[w] = '0; w32[w] = '0;
    end
    repeat (3) @(posedge clk);
    #1;
    chk("R1 narrow hits in reset", 32'({any24, hit24}), 32'd0);
    chk("R1 wide hits in reset", 32'({any32, hit32}), 32'd0);
    rstN = 1'b1;
    @(posedge clk); #1;
    chk("R1 narrow hits after reset", 32'({any24, hit24}), 32'd0);
    sweepRead("R1 R4 reset readback");

    // Distinct value into every index, then read everything back.
    for (int i = 0; i < 256; i++) wr(i, 8'(i) ^ 8'h5A);
    sweepRead("R2 R3 R5 R6 full map");

    // Control bit 0 must ignore writes in both directions.
    wr('h42, 8'hFF); wr('h7A, 8'hFF);
    regIdx = 8'h42; #1; chk("R4 R5 narrow ctrl w0", 32'(rd24), 32'h02);
    regIdx = 8'h7A; #1; chk("R4 R5 wide ctrl w0", 32'(rd32), 32'h06);
    wr('h4A, 8'h00); wr('h84, 8'h00);
    regIdx = 8'h4A; #1; chk("R4 narrow ctrl w1", 32'(rd24), 32'h01);
    regIdx = 8'h84; #1; chk("R4 wide ctrl w1", 32'(rd32), 32'h01);
    wr('h84, 8'h02);
    regIdx = 8'h84; #1; chk("R5 wide width 01", 32'(rd32), 32'h03);
    sweepRead("R4 R5 R6 after ctrl writes");

    // Configuration A: aligned mask, one-step limit, two windows that cannot hit.
    setWin(0, 16'h1200, 16'hFF00, 32'h0012_0000, 32'hFFFF_0000);
    setWin(1, 16'h1000, 16'h1100, 32'h0010_0000, 32'h0011_0000);
    setWin(2, 16'h0000, 16'h0000, 32'h0000_0000, 32'h0000_0000);
    setWin(3, 16'h2000, 16'h2000, 32'h0000_1000, 32'h0000_1001);
    sweepNarrow("R7 R8 R9 R10 config A");

    // Latency: the hit flag changes only at the edge following the address.
    chkHits(32'h0012_0000, "R11 setup");
    a24 = 24'h00_0000; a32 = 32'h0; #1;
    chk("R11 narrow holds before edge", 32'(hit24), 32'h1);
    chk("R11 wide holds before edge", 32'(hit32), 32'h1);
    @(posedge clk); #1;
    chk("R11 narrow after edge", 32'({any24, hit24}), 32'h0);
    chk("R11 wide after edge", 32'({any32, hit32}), 32'h0);

    // Configuration B: sparse mask, inverted limit, exact mask, partial limit.
    setWin(0, 16'h2050, 16'hF0F0, 32'h8000_0000, 32'h8000_0000);
    setWin(1, 16'h3000, 16'h2000, 32'h0000_0100, 32'h0030_0000);
    setWin(2, 16'h1234, 16'hFFFF, 32'h0000_0055, 32'h0000_00FF);
    setWin(3, 16'h2000, 16'h2180, 32'h1234_5678, 32'h1234_5679);
    sweepNarrow("R7 R8 R9 R10 config B");

    anchors = '{32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0100, 32'h0030_0000,
                32'h1234_5678, 32'h0000_0055, 32'hFFFF_FFFF, 32'h0001_2355};
    for (int k = 0; k < 8; k++)
      for (int d = -2; d <= 2; d++)
        chkHits(anchors[k] + 32'(d), "R7 R8 wide boundaries");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule